// File: doc/BRIEF.md
# Framed Serial Command Decoder

This block sits between a four-wire framed serial port and the set-point sequencers of four regulator channels. A host raises frame sync, then sends a 16-bit word most significant bit first. Frame sync and data are captured on the falling edge of the serial clock. The upper byte of the word carries a read/write flag, a bank bit, a two-bit channel number and a four-bit device identifier. The lower byte carries a four-bit voltage code and the action flags.

For write words that are accepted, the decoder emits a single-cycle strobe after the last bit. The strobe is one of: initialise, program (one channel or all channels), or disable. It comes with the channel index and the voltage code.

For read words, the block drives the addressed channel's status byte on the data-out line during the last eight bit slots of the same frame. That line is modelled as a data bit plus an output enable, so it can be wired to an open-drain or tri-state pad.

Two devices can share one bus and act as one eight-channel unit. Each device compares the bank bit of the word against its own strap pin. Broadcast actions (initialise and global program) reach both devices.

Top module: `fcmd_decoder`

## Requirements
- R1: Frame sync and serial data are sampled on the falling edge of `i_sclk`. A sampled-high frame sync restarts the frame. The first data bit (bit 15) is taken on the next falling edge with frame sync low. A frame cut short by a new frame sync before its 16th bit produces no strobe.
- R2: A word is accepted only when bits 11:8 equal the device ID (default 4'b1111). Any other word produces no strobe and leaves `o_sdo_oe` low.
- R3: Channel-addressed words (single program, disable, read) are accepted only when bit 14 equals `i_bank`. Initialise and global program are accepted whatever bit 14 holds.
- R4: A write word (bit 15 = 0) with data bit 0 = 1 pulses `o_init_stb`. This takes priority over every other flag in the data byte.
- R5: A write word with bit 0 = 0 and bit 3 = 1 pulses `o_dis_stb`, with `o_chan` equal to bits 13:12.
- R6: A write word with bits 0 and 3 clear and bit 2 set pulses `o_prog_stb` with `o_prog_all` = 1 and `o_code` equal to bits 7:4.
- R7: A write word with bits 0, 2 and 3 all clear pulses `o_prog_stb` with `o_prog_all` = 0, `o_chan` equal to bits 13:12 and `o_code` equal to bits 7:4. Bit 1 is ignored.
- R8: A strobe starts at the falling edge that samples the 16th bit and lasts exactly one serial clock period. `o_chan` and `o_code` read zero whenever no strobe is active.
- R9: For an accepted read word (bit 15 = 1), the status byte of the addressed channel is driven MSB first. Status byte k is `i_status[8k+7:8k]`. Each bit is driven from the rising edge just before the falling edges that sample data bits 7..0. `o_sdo_oe` is high only in those eight slots, and a read word produces no strobe.
- R10: Data arriving after the 16th bit and before the next frame sync is ignored.
- R11: During reset all strobes, `o_chan`, `o_code`, `o_sdo` and `o_sdo_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_sclk | input | 1 | Serial clock; inputs sampled on its falling edge |
| i_rst_n | input | 1 | Asynchronous active-low reset |
| i_fs | input | 1 | Frame sync; high restarts the frame |
| i_sdi | input | 1 | Serial data in, MSB first |
| i_bank | input | 1 | Bank strap compared with word bit 14 |
| i_status | input | 32 | Four per-channel status bytes, channel k in bits 8k+7:8k |
| o_sdo | output | 1 | Serial status data |
| o_sdo_oe | output | 1 | Output enable for `o_sdo` |
| o_init_stb | output | 1 | Initialise strobe |
| o_prog_stb | output | 1 | Program strobe |
| o_prog_all | output | 1 | Program applies to all channels |
| o_dis_stb | output | 1 | Channel disable strobe |
| o_chan | output | 2 | Channel index for the strobe |
| o_code | output | 4 | Voltage code for the strobe |

## Verification
A bit counter that is off by one sample shifts the whole word. The error then shows on the next accepted frame: the wrong strobe or a misaligned channel and code at the 16th falling edge. It also shifts the read window by a slot, which is visible on the first rising edge where `o_sdo_oe` should change.

A status shift register that is loaded from the wrong channel, or shifted in the wrong direction, corrupts `o_sdo` within the eight slots of the first read. A decode priority error appears on the first word that sets more than one action flag. The sweep covers every header byte against a set of data bytes on both banks, so each of these faults is exposed inside a single frame.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
    localparam int WORD_W  = 16;
    localparam int HDR_W   = 8;
    localparam int STAT_W  = 8;
    localparam int CNT_W   = $clog2(WORD_W + 1);
    localparam int ID_W    = 4;
    localparam int CODE_W  = 4;
    localparam int CH_W    = 2;

    // bit positions inside the full word (behaviour depends on them)
    localparam int P_RW    = 15;
    localparam int P_BANK  = 14;
    localparam int P_CH    = 12;
    localparam int P_ID    = 8;
    localparam int P_CODE  = 4;
    localparam int P_OFF   = 3;
    localparam int P_ALL   = 2;
    localparam int P_INIT  = 0;

    // slot where the header byte is complete
    localparam int HDR_CNT = HDR_W;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_INIT,
        OP_ALL,
        OP_ONE,
        OP_OFF
    } op_e;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
        logic              done;
    } rx_t;

    typedef struct packed {
        logic              act;
        logic [STAT_W-1:0] dat;
    } tx_t;
endpackage

// File: rtl/fcmd_deframer.sv
module fcmd_deframer
    import fcmd_pkg::*;
(
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              fs,
    input  logic              sdi,
    output logic [CNT_W-1:0]  cnt,
    output logic [WORD_W-1:0] word,
    output logic              done
);
    rx_t rx_q, rx_d;

    always_comb begin
        rx_d      = rx_q;
        rx_d.done = 1'b0;
        if (fs) begin
            rx_d.cnt = '0;
        end else if (rx_q.cnt < CNT_W'(WORD_W)) begin
            rx_d.sh   = {rx_q.sh[WORD_W-2:0], sdi};
            rx_d.cnt  = rx_q.cnt + CNT_W'(1);
            rx_d.done = (rx_q.cnt == CNT_W'(WORD_W - 1));
        end
    end

    always_ff @(negedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '{cnt: CNT_W'(WORD_W), sh: '0, done: 1'b0};
        end else begin
            rx_q <= rx_d;
        end
    end

    assign cnt  = rx_q.cnt;
    assign word = rx_q.sh;
    assign done = rx_q.done;

    assert_sync_restart_R1: assert property (@(negedge sclk) disable iff (!rst_n)
        fs |=> (rx_q.cnt == '0));
    assert_done_full_word_R1: assert property (@(negedge sclk) disable iff (!rst_n)
        rx_q.done |-> ($past(rx_q.cnt) == CNT_W'(WORD_W - 1) && !$past(fs)));
    assert_done_single_R8: assert property (@(negedge sclk) disable iff (!rst_n)
        rx_q.done |=> !rx_q.done);
    assert_idle_frozen_R10: assert property (@(negedge sclk) disable iff (!rst_n)
        (rx_q.cnt == CNT_W'(WORD_W) && !fs) |=> (rx_q.cnt == CNT_W'(WORD_W) && $stable(rx_q.sh)));
endmodule

// File: rtl/fcmd_decode.sv
module fcmd_decode
    import fcmd_pkg::*;
#(
    parameter logic [ID_W-1:0] DEV_ID = 4'hF
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word,
    input  logic              done,
    input  logic              bank,
    output logic              init_stb,
    output logic              prog_stb,
    output logic              prog_all,
    output logic              dis_stb,
    output logic [CH_W-1:0]   chan,
    output logic [CODE_W-1:0] code
);
    logic id_ok, bank_ok, is_wr;
    op_e  op;

    assign id_ok   = (word[P_ID +: ID_W] == DEV_ID);
    assign bank_ok = (word[P_BANK] == bank);
    assign is_wr   = !word[P_RW];

    always_comb begin
        op = OP_NONE;
        if (done && id_ok && is_wr) begin
            if (word[P_INIT])                op = OP_INIT;
            else if (word[P_OFF])            op = bank_ok ? OP_OFF : OP_NONE;
            else if (word[P_ALL])            op = OP_ALL;
            else                             op = bank_ok ? OP_ONE : OP_NONE;
        end
    end

    always_comb begin
        init_stb = (op == OP_INIT);
        prog_stb = (op == OP_ALL) || (op == OP_ONE);
        prog_all = (op == OP_ALL);
        dis_stb  = (op == OP_OFF);
        chan     = (op == OP_NONE) ? '0 : word[P_CH +: CH_W];
        code     = (op == OP_NONE) ? '0 : word[P_CODE +: CODE_W];
    end

    assert_one_action_R4: assert property (@(negedge sclk) disable iff (!rst_n)
        $onehot0({init_stb, prog_stb, dis_stb}));
    assert_strobe_needs_id_R2: assert property (@(negedge sclk) disable iff (!rst_n)
        (init_stb || prog_stb || dis_stb) |-> (done && word[P_ID +: ID_W] == DEV_ID));
    assert_chan_cmd_bank_R3: assert property (@(negedge sclk) disable iff (!rst_n)
        (dis_stb || (prog_stb && !prog_all)) |-> (word[P_BANK] == bank));
endmodule

// File: rtl/fcmd_status_tx.sv
module fcmd_status_tx
    import fcmd_pkg::*;
#(
    parameter int              NCH    = 4,
    parameter logic [ID_W-1:0] DEV_ID = 4'hF
) (
    input  logic                  sclk,
    input  logic                  rst_n,
    input  logic [CNT_W-1:0]      cnt,
    input  logic [WORD_W-1:0]     word,
    input  logic                  bank,
    input  logic [NCH*STAT_W-1:0] status,
    output logic                  sdo,
    output logic                  sdo_oe
);
    tx_t tx_q, tx_d;

    logic [HDR_W-1:0]  hdr;
    logic [CH_W-1:0]   hdr_ch;
    logic              rd_hit;
    logic              in_slot;
    logic [STAT_W-1:0] sel_byte;

    // while cnt equals HDR_CNT the low byte of the shifter is the header
    assign hdr      = word[HDR_W-1:0];
    assign hdr_ch   = hdr[P_CH-HDR_W +: CH_W];
    assign rd_hit   = hdr[P_RW-HDR_W] && (hdr[P_BANK-HDR_W] == bank)
                      && (hdr[P_ID-HDR_W +: ID_W] == DEV_ID);
    assign sel_byte = status[int'(hdr_ch)*STAT_W +: STAT_W];
    assign in_slot  = (cnt >= CNT_W'(HDR_CNT)) && (cnt < CNT_W'(WORD_W));

    always_comb begin
        tx_d = tx_q;
        if (!in_slot) begin
            tx_d.act = 1'b0;
        end else if (cnt == CNT_W'(HDR_CNT)) begin
            tx_d.act = rd_hit;
            tx_d.dat = sel_byte;
        end else begin
            tx_d.dat = {tx_q.dat[STAT_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '{act: 1'b0, dat: '0};
        end else begin
            tx_q <= tx_d;
        end
    end

    assign sdo_oe = tx_q.act;
    assign sdo    = tx_q.act & tx_q.dat[STAT_W-1];

    assert_read_start_R9: assert property (@(posedge sclk) disable iff (!rst_n)
        $rose(tx_q.act) |-> ($past(cnt) == CNT_W'(HDR_CNT)));
    assert_read_end_R9: assert property (@(posedge sclk) disable iff (!rst_n)
        $fell(tx_q.act) |-> ($past(cnt) == CNT_W'(WORD_W) || $past(cnt) < CNT_W'(HDR_CNT)));
    assert_quiet_when_idle_R10: assert property (@(posedge sclk) disable iff (!rst_n)
        (cnt == CNT_W'(WORD_W)) |=> !tx_q.act);
endmodule

// File: rtl/fcmd_decoder.sv
module fcmd_decoder
    import fcmd_pkg::*;
#(
    parameter int              NCH    = 4,
    parameter logic [ID_W-1:0] DEV_ID = 4'hF
) (
    input  logic                  i_sclk,
    input  logic                  i_rst_n,
    input  logic                  i_fs,
    input  logic                  i_sdi,
    input  logic                  i_bank,
    input  logic [NCH*STAT_W-1:0] i_status,
    output logic                  o_sdo,
    output logic                  o_sdo_oe,
    output logic                  o_init_stb,
    output logic                  o_prog_stb,
    output logic                  o_prog_all,
    output logic                  o_dis_stb,
    output logic [CH_W-1:0]       o_chan,
    output logic [CODE_W-1:0]     o_code
);
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] word;
    logic              done;

    fcmd_deframer u_rx (
        .sclk  (i_sclk),
        .rst_n (i_rst_n),
        .fs    (i_fs),
        .sdi   (i_sdi),
        .cnt   (cnt),
        .word  (word),
        .done  (done)
    );

    fcmd_decode #(.DEV_ID(DEV_ID)) u_dec (
        .sclk     (i_sclk),
        .rst_n    (i_rst_n),
        .word     (word),
        .done     (done),
        .bank     (i_bank),
        .init_stb (o_init_stb),
        .prog_stb (o_prog_stb),
        .prog_all (o_prog_all),
        .dis_stb  (o_dis_stb),
        .chan     (o_chan),
        .code     (o_code)
    );

    fcmd_status_tx #(.NCH(NCH), .DEV_ID(DEV_ID)) u_tx (
        .sclk   (i_sclk),
        .rst_n  (i_rst_n),
        .cnt    (cnt),
        .word   (word),
        .bank   (i_bank),
        .status (i_status),
        .sdo    (o_sdo),
        .sdo_oe (o_sdo_oe)
    );

    assert_read_no_strobe_R9: assert property (@(negedge i_sclk) disable iff (!i_rst_n)
        (done && word[P_RW]) |-> !(o_init_stb || o_prog_stb || o_dis_stb));
endmodule

// File: tb/tb_fcmd_decoder.sv
module tb_fcmd_decoder;
    logic sclk = 1'b0;
    always #5 sclk = ~sclk;

    logic rst_n, fs, sdi, bank;
    logic [7:0] stat [4];
    logic [31:0] status_bus;
    logic sdo, sdo_oe, init_stb, prog_stb, prog_all, dis_stb;
    logic [1:0] chan;
    logic [3:0] code;

    assign status_bus = {stat[3], stat[2], stat[1], stat[0]};

    fcmd_decoder dut (
        .i_sclk(sclk), .i_rst_n(rst_n), .i_fs(fs), .i_sdi(sdi), .i_bank(bank),
        .i_status(status_bus), .o_sdo(sdo), .o_sdo_oe(sdo_oe),
        .o_init_stb(init_stb), .o_prog_stb(prog_stb), .o_prog_all(prog_all),
        .o_dis_stb(dis_stb), .o_chan(chan), .o_code(code)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(string r, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", r, act, exp);
        end
    endtask

    function automatic logic [9:0] outs();
        return {init_stb, prog_stb, prog_all, dis_stb, chan, code};
    endfunction

    // {rd_hit, init, prog, all, dis, chan[1:0], code[3:0]}
    function automatic logic [10:0] model(logic bk, logic [7:0] h, logic [7:0] d);
        logic id_ok, bk_ok;
        logic [10:0] e;
        id_ok = (h[3:0] == 4'hF);
        bk_ok = (h[6] == bk);
        e = '0;
        if (id_ok) begin
            if (h[7])       e[10] = bk_ok;
            else if (d[0])  e[9] = 1'b1;
            else if (d[3])  e[6] = bk_ok;
            else if (d[2])  begin e[8] = 1'b1; e[7] = 1'b1; end
            else            e[8] = bk_ok;
        end
        if (e[9:6] != 4'b0) e[5:0] = {h[5:4], d[7:4]};
        return e;
    endfunction

    function automatic string tag(logic bk, logic [7:0] h, logic [7:0] d);
        if (h[3:0] != 4'hF) return "R2";
        if (h[7])           return (h[6] == bk) ? "R9" : "R3";
        if (d[0])           return "R4";
        if (d[3])           return (h[6] == bk) ? "R5" : "R3";
        if (d[2])           return (h[6] == bk) ? "R6" : "R3";
        return (h[6] == bk) ? "R7" : "R3";
    endfunction

    task automatic frame(logic [15:0] w, int nbits, logic [10:0] e, string t, logic [7:0] sb);
        @(posedge sclk); #1 fs = 1'b1; sdi = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            @(posedge sclk); #1 fs = 1'b0; sdi = w[15-i]; #1;
            chk((e[10] ? "R9" : t), {15'b0, sdo_oe}, {15'b0, e[10] && i >= 8});
            if (e[10] && i >= 8) chk("R9", {15'b0, sdo}, {15'b0, sb[15-i]});
            @(negedge sclk); #2;
            if (i == 15) chk(t, {6'b0, outs()}, {6'b0, e[9:0]});
            else         chk((nbits < 16) ? "R1" : "R8", {6'b0, outs()}, 16'b0);
        end
        if (nbits == 16) begin
            @(posedge sclk); #1 sdi = ~sdi; #1;
            chk("R9", {15'b0, sdo_oe}, 16'b0);
            chk("R8", {6'b0, outs()}, {6'b0, e[9:0]});
            @(negedge sclk); #2;
            chk("R8", {6'b0, outs()}, 16'b0);
            @(posedge sclk); #1 sdi = 1'b1;
            @(negedge sclk); #2;
            chk("R10", {6'b0, outs()}, 16'b0);
            chk("R10", {15'b0, sdo_oe}, 16'b0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge sclk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] dl [8];
        dl = '{8'h00, 8'h09, 8'h57, 8'hA8, 8'hF4, 8'h3C, 8'h62, 8'h1B};
        rst_n = 1'b0; fs = 1'b0; sdi = 1'b0; bank = 1'b0;
        for (int c = 0; c < 4; c++) stat[c] = 8'(c * 16 + 5);
        repeat (3) @(posedge sclk);
        #2;
        chk("R11", {5'b0, sdo, sdo_oe, outs()}, 16'b0);
        @(negedge sclk); #2;
        chk("R11", {5'b0, sdo, sdo_oe, outs()}, 16'b0);
        @(posedge sclk); #1 rst_n = 1'b1;

        // R1: write frame cut short, then a full one
        frame(16'h0F_40, 10, 11'b0, "R1", 8'h00);
        frame(16'h0F_40, 16, model(1'b0, 8'h0F, 8'h40), "R1", 8'h00);
        // R1: read frame cut short; output released once restarted
        frame(16'h8F_00, 12, model(1'b0, 8'h8F, 8'h00), "R1", stat[0]);
        frame(16'h9F_00, 16, model(1'b0, 8'h9F, 8'h00), "R1", stat[1]);

        for (int b = 0; b < 2; b++) begin
            for (int h = 0; h < 256; h++) begin
                for (int di = 0; di < 8; di++) begin
                    logic [7:0] hh, dd;
                    hh = 8'(h); dd = dl[di];
                    bank = b[0];
                    for (int c = 0; c < 4; c++)
                        stat[c] = (di == 0) ? 8'h00 : 8'(h * 29 + di * 53 + c * 71 + b);
                    frame({hh, dd}, 16, model(bank, hh, dd), tag(bank, hh, dd), stat[hh[5:4]]);
                end
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule